// File: doc/BRIEF.md
# Housekeeping Packet Receiver and Checker

This block sits behind a byte-level I2C slave, after address matching, and parses the short link-layer packet carried by a write transfer. The upstream slave gives it a one-cycle strobe per received byte and one-cycle pulses for START (including repeated START) and STOP conditions.

The first byte of a packet is a header. Its upper three bits give the number of payload bytes minus one, and its lower five bits select one of 32 modules. The second byte is a checksum. Between one and eight payload bytes follow it. Each payload byte is passed on with its position in the packet. The block keeps a running 8-bit sum of the payload. When the closing STOP arrives, it reports either a good frame or a corrupt frame that must be sent again.

Framing faults are reported on separate one-cycle flags:
- a void message, where START is followed directly by STOP;
- a truncated payload;
- surplus bytes after the payload.

Top module: `hk_pkt_rx`

## Requirements
- R1: Header bits [7:5] hold the payload length minus one, and bits [4:0] hold the module number. One cycle after the header byte, `count_o` shows 1..8 and `module_o` shows the module number. Both hold until the next START, which clears them to 0.
- R2: The byte after the header is the checksum, and the bytes after that are payload. One cycle after each payload byte, `data_valid_o` pulses with the byte on `data_o` and its zero-based position on `data_idx_o`.
- R3: After all announced payload bytes have arrived, a STOP makes `frame_ok_o` pulse for one cycle on the next cycle if (checksum − payload sum) mod 256 is 0.
- R4: In the same situation, a nonzero difference makes `frame_bad_o` pulse instead, requesting retransmission.
- R5: A START in any state discards the partial packet, including its sum, and makes the parser wait for a header. No frame result is given for the discarded packet.
- R6: A STOP directly after START, with no byte in between, makes `void_err_o` pulse for one cycle on the next cycle.
- R7: A STOP after the header but before the last payload byte makes `trunc_err_o` pulse on the next cycle. Neither `frame_ok_o` nor `frame_bad_o` pulses.
- R8: A byte that arrives after the last payload byte and before STOP makes `overrun_err_o` pulse on the next cycle. The byte is not output and does not enter the sum.
- R9: With no START since the last STOP or reset, bytes and STOPs have no effect on any output.
- R10: When pulses coincide in one cycle, START wins over STOP, and STOP wins over a byte strobe. The losing events are ignored.
- R11: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen, one-cycle pulse |
| stop_i | input | 1 | STOP seen, one-cycle pulse |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| module_o | output | 5 | Module number of the current packet |
| count_o | output | 4 | Announced payload length, 0 before a header |
| data_valid_o | output | 1 | Payload byte valid |
| data_o | output | 8 | Payload byte |
| data_idx_o | output | 3 | Payload byte position |
| frame_ok_o | output | 1 | Good frame pulse |
| frame_bad_o | output | 1 | Checksum mismatch pulse, retransmission needed |
| void_err_o | output | 1 | START followed directly by STOP |
| trunc_err_o | output | 1 | STOP before the payload was complete |
| overrun_err_o | output | 1 | Surplus byte after the payload |

## Verification
The bench goes after the following corner cases:
- A checksum whose addition wraps past 8 bits. A design that keeps more than 8 bits would wrongly flag a good frame as bad.
- The one-byte and eight-byte length extremes. An off-by-one in the length decode would cause a truncation error or an overrun.
- A restart in the middle of a frame. A design that keeps the old partial sum would reject the next, valid frame.
- Colliding START, STOP and byte pulses, a surplus byte, and traffic while idle. A design with the wrong priority, or one that lets a surplus byte into the sum, would produce a void error where none belongs, an output byte, or a false checksum verdict.

// File: rtl/hk_pkt_pkg.sv
package hk_pkt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CSUM,
    ST_DATA,
    ST_DONE
  } hk_state_e;
endpackage

// File: rtl/hk_sum_acc.sv
module hk_sum_acc #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] sum_o
);
  logic [DW-1:0] sum_q;

  // modular sum, carries dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_q + byte_i;
  end

  assign sum_o = sum_q;

  assert_clr_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_o == '0));
endmodule

// File: rtl/hk_byte_cnt.sv
module hk_byte_cnt #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (inc_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == limit_i);

  assert_no_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && last_o) |=> !inc_i);
endmodule

// File: rtl/hk_pkt_fsm.sv
module hk_pkt_fsm
  import hk_pkt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic byte_valid_i,
  input  logic last_i,
  output logic clr_o,
  output logic hdr_we_o,
  output logic csum_we_o,
  output logic data_we_o,
  output logic done_o,
  output logic void_o,
  output logic trunc_o,
  output logic ovr_o
);
  hk_state_e state_q, state_d;
  logic take_start, take_stop, take_byte;
  logic done_q, void_q, trunc_q, ovr_q;

  // START > STOP > byte
  assign take_start = start_i;
  assign take_stop  = !start_i && stop_i;
  assign take_byte  = !start_i && !stop_i && byte_valid_i;

  always_comb begin
    state_d = state_q;
    if (take_start)      state_d = ST_HDR;
    else if (take_stop)  state_d = ST_IDLE;
    else if (take_byte) begin
      case (state_q)
        ST_HDR:  state_d = ST_CSUM;
        ST_CSUM: state_d = ST_DATA;
        ST_DATA: state_d = last_i ? ST_DONE : ST_DATA;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      void_q  <= 1'b0;
      trunc_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= take_stop && (state_q == ST_DONE);
      void_q  <= take_stop && (state_q == ST_HDR);
      trunc_q <= take_stop && ((state_q == ST_CSUM) || (state_q == ST_DATA));
      ovr_q   <= take_byte && (state_q == ST_DONE);
    end
  end

  assign clr_o     = take_start;
  assign hdr_we_o  = take_byte && (state_q == ST_HDR);
  assign csum_we_o = take_byte && (state_q == ST_CSUM);
  assign data_we_o = take_byte && (state_q == ST_DATA);
  assign done_o    = done_q;
  assign void_o    = void_q;
  assign trunc_o   = trunc_q;
  assign ovr_o     = ovr_q;

  assert_start_rearms_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_HDR));
  assert_void_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    void_q |-> $past(stop_i));
  assert_done_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_DONE) && take_byte) |=> (state_q == ST_DONE));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && !start_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/hk_pkt_rx.sv
module hk_pkt_rx #(
  parameter int CNT_W = 3,
  parameter int MOD_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_valid_i,
  input  logic [CNT_W+MOD_W-1:0] byte_i,
  output logic [MOD_W-1:0]   module_o,
  output logic [CNT_W:0]     count_o,
  output logic               data_valid_o,
  output logic [CNT_W+MOD_W-1:0] data_o,
  output logic [CNT_W-1:0]   data_idx_o,
  output logic               frame_ok_o,
  output logic               frame_bad_o,
  output logic               void_err_o,
  output logic               trunc_err_o,
  output logic               overrun_err_o
);
  localparam int DW = CNT_W + MOD_W;

  logic clr, hdr_we, csum_we, data_we, done, last;
  logic [DW-1:0]    sum, csum_q, dat_q;
  logic [CNT_W-1:0] idx, cnt_m1_q, idx_q;
  logic [MOD_W-1:0] mod_q;
  logic             hdr_vld_q, dv_q;
  logic [DW-1:0]    diff;

  hk_pkt_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_i), .stop_i(stop_i), .byte_valid_i(byte_valid_i),
    .last_i(last),
    .clr_o(clr), .hdr_we_o(hdr_we), .csum_we_o(csum_we), .data_we_o(data_we),
    .done_o(done), .void_o(void_err_o), .trunc_o(trunc_err_o), .ovr_o(overrun_err_o)
  );

  hk_sum_acc #(.DW(DW)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .add_i(data_we),
    .byte_i(byte_i), .sum_o(sum)
  );

  hk_byte_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .inc_i(data_we),
    .limit_i(cnt_m1_q), .idx_o(idx), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q     <= '0;
      cnt_m1_q  <= '0;
      hdr_vld_q <= 1'b0;
      csum_q    <= '0;
    end else if (clr) begin
      mod_q     <= '0;
      cnt_m1_q  <= '0;
      hdr_vld_q <= 1'b0;
      csum_q    <= '0;
    end else begin
      if (hdr_we) begin
        cnt_m1_q  <= byte_i[DW-1:MOD_W];
        mod_q     <= byte_i[MOD_W-1:0];
        hdr_vld_q <= 1'b1;
      end
      if (csum_we) csum_q <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q  <= 1'b0;
      dat_q <= '0;
      idx_q <= '0;
    end else begin
      dv_q <= data_we;
      if (data_we) begin
        dat_q <= byte_i;
        idx_q <= idx;
      end
    end
  end

  assign diff          = csum_q - sum;
  assign module_o      = mod_q;
  assign count_o       = hdr_vld_q ? ({1'b0, cnt_m1_q} + 1'b1) : '0;
  assign data_valid_o  = dv_q;
  assign data_o        = dat_q;
  assign data_idx_o    = idx_q;
  assign frame_ok_o    = done && (diff == '0);
  assign frame_bad_o   = done && (diff != '0);

  assert_one_verdict_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_ok_o, frame_bad_o, void_err_o, trunc_err_o}));
  assert_ok_after_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> $past(stop_i));
  assert_bad_after_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bad_o |-> $past(stop_i));
  assert_idx_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> ({1'b0, data_idx_o} < count_o));
  assert_hdr_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && hdr_vld_q) |=> $stable(module_o));
  assert_no_data_on_ovr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_err_o |-> !data_valid_o);
endmodule

// File: tb/sim_hk_pkt_rx.sv
module sim_hk_pkt_rx;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, byte_valid_i = 0;
  logic [7:0] byte_i = '0;
  logic [4:0] module_o;
  logic [3:0] count_o;
  logic data_valid_o, frame_ok_o, frame_bad_o, void_err_o, trunc_err_o, overrun_err_o;
  logic [7:0] data_o;
  logic [2:0] data_idx_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hk_pkt_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .module_o(module_o), .count_o(count_o), .data_valid_o(data_valid_o),
    .data_o(data_o), .data_idx_o(data_idx_o), .frame_ok_o(frame_ok_o),
    .frame_bad_o(frame_bad_o), .void_err_o(void_err_o), .trunc_err_o(trunc_err_o),
    .overrun_err_o(overrun_err_o)
  );

  // {hdr, csum, data0..data7}
  localparam logic [79:0] VEC [5] = '{
    {8'h22, 8'h22, 64'h6DB5_0000_0000_0000},
    {8'h00, 8'hFF, 64'hFF00_0000_0000_0000},
    {8'hFF, 8'h24, 64'h0102_0304_0506_0708},
    {8'h45, 8'h02, 64'h8080_0100_0000_0000},
    {8'h7F, 8'hA0, 64'h1020_3040_0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drives for one cycle starting at a negedge; outputs of that edge visible on return
  task automatic step(bit s, bit p, bit v, logic [7:0] b);
    start_i = s; stop_i = p; byte_valid_i = v; byte_i = b;
    @(negedge clk);
    start_i = 0; stop_i = 0; byte_valid_i = 0; byte_i = '0;
  endtask

  function automatic logic [5:0] flags();
    return {frame_ok_o, frame_bad_o, void_err_o, trunc_err_o, overrun_err_o, data_valid_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset flags", {26'd0, flags()}, 0);
    check("R11 reset hdr", {23'd0, module_o, count_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      logic [7:0] hdr, cs, sum;
      int n;
      hdr = VEC[v][79:72]; cs = VEC[v][71:64]; sum = '0;
      n = hdr[7:5] + 1;
      step(1, 0, 0, 0);
      step(0, 0, 1, hdr);
      check("R1 module", module_o, hdr[4:0]);
      check("R1 count", count_o, n);
      step(0, 0, 1, cs);
      check("R2 csum not output", data_valid_o, 0);
      for (int i = 0; i < n; i++) begin
        logic [7:0] d;
        d = VEC[v][63-8*i -: 8];
        sum = sum + d;
        step(0, 0, 1, d);
        check("R2 valid", data_valid_o, 1);
        check("R2 data", data_o, d);
        check("R2 idx", data_idx_o, i);
      end
      step(0, 1, 0, 0);
      check("R3 ok", frame_ok_o, (cs - sum) == 8'h00);
      check("R4 bad", frame_bad_o, (cs - sum) != 8'h00);
      @(negedge clk);
      check("R3 one pulse", {frame_ok_o, frame_bad_o}, 0);
      check("R1 held after stop", {module_o, count_o}, {hdr[4:0], 4'(n)});
    end

    // R1: START clears header
    step(1, 0, 0, 0);
    check("R1 start clears", {module_o, count_o}, 0);
    // R6: void
    step(0, 1, 0, 0);
    check("R6 void", flags(), 6'b001000);

    // R7: truncated in payload and right after header
    step(1, 0, 0, 0); step(0, 0, 1, 8'h45); step(0, 0, 1, 8'h01); step(0, 0, 1, 8'h01);
    step(0, 1, 0, 0);
    check("R7 trunc data", flags(), 6'b000100);
    step(1, 0, 0, 0); step(0, 0, 1, 8'h22);
    step(0, 1, 0, 0);
    check("R7 trunc csum", flags(), 6'b000100);

    // R8: overrun byte not output, not summed
    step(1, 0, 0, 0); step(0, 0, 1, 8'h00); step(0, 0, 1, 8'h11); step(0, 0, 1, 8'h11);
    step(0, 0, 1, 8'h99);
    check("R8 overrun", flags(), 6'b000010);
    step(0, 1, 0, 0);
    check("R8 ok after overrun", flags(), 6'b100000);

    // R9: idle traffic ignored
    step(0, 0, 1, 8'h55);
    check("R9 idle byte", flags(), 0);
    step(0, 1, 0, 0);
    check("R9 idle stop", flags(), 0);
    check("R9 hdr held", {module_o, count_o}, {5'd0, 4'd1});

    // R5: restart mid-frame drops partial sum
    step(1, 0, 0, 0); step(0, 0, 1, 8'h22); step(0, 0, 1, 8'h22); step(0, 0, 1, 8'h01);
    step(1, 0, 0, 0);
    check("R5 restart clears", {module_o, count_o}, 0);
    step(0, 0, 1, 8'h00); step(0, 0, 1, 8'h07); step(0, 0, 1, 8'h07);
    step(0, 1, 0, 0);
    check("R5 ok after restart", flags(), 6'b100000);

    // R10: priority
    step(1, 1, 0, 0);
    check("R10 start over stop", flags(), 0);
    step(0, 1, 0, 0);
    check("R10 void after start+stop", void_err_o, 1);
    step(1, 0, 1, 8'h22);
    check("R10 start over byte", count_o, 0);
    step(0, 1, 0, 0);
    check("R10 void after start+byte", void_err_o, 1);
    step(1, 0, 0, 0); step(0, 0, 1, 8'h00); step(0, 0, 1, 8'h05);
    step(0, 1, 1, 8'h05);
    check("R10 stop over byte", flags(), 6'b000100);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule